// File: doc/BRIEF.md
# Phase Accumulator Oscillator Ring with Hard Sync

This block holds a set of voice oscillators that share one clock. Each oscillator keeps a 24-bit phase accumulator. On every clock it adds a 16-bit frequency word into the accumulator. From the top twelve phase bits it produces three 12-bit shapes: a sawtooth, a folded triangle and a pulse. The pulse compares the phase against a 12-bit pulse width.

The oscillators are linked in a ring. Each one takes a neighbour as its source. The source's phase can restart the destination through hard sync. The source's MSB can also flip the triangle fold through ring modulation. A per-oscillator test bit holds the phase at zero and forces the pulse high. Higher-level voice logic reads the shapes directly. It also reads each oscillator's MSB and its one-cycle MSB-rising flag.

Top module: `phase_osc_ring`

## Requirements
- R1: When test and sync are inactive, each clock adds the frequency word, zero-extended, to the accumulator modulo 2^24. The sawtooth and MSB outputs expose the result one cycle later.
- R2: While an oscillator's test bit is 1, its accumulator is zero after every clock. The first clock with test at 0 adds the frequency word to zero.
- R3: The MSB-rising output is 1 for exactly the cycle after a clock whose addition turned bit 23 from 0 to 1. It is never 1 while test is held.
- R4: With sync enabled, an oscillator's accumulator is cleared on any clock where its source's addition turns the source's bit 23 from 0 to 1. This applies after all oscillators have advanced, so the sync clear takes priority over the destination's own addition.
- R5: The clear of R4 is suppressed when, on that same clock, the source has its own sync enabled and the source's own source also has a rising MSB.
- R6: The sawtooth output equals accumulator bits 23..12.
- R7: The triangle output bit n equals accumulator bit n+11 for n = 1..11, and bit 0 is 0. When the fold bit is 1, those eleven bits are inverted. The fold bit is the accumulator MSB when ring modulation is off.
- R8: With ring modulation on, the fold bit is the own MSB XOR the inverted source MSB.
- R9: With test at 0, the pulse output is 0xFFF when the accumulator bits 23..12 sampled before the previous clock were greater than or equal to the pulse width. Otherwise it is 0x000.
- R10: While test is 1, the pulse output is 0xFFF for any pulse width.
- R11: A synchronous active-high reset clears every accumulator, the pulse compare register and the MSB-rising flags. As a result, all shapes and flags read 0 after reset when test is 0.
- R12: Oscillator k takes oscillator (k+2) mod 3 as its source, which is the previous index in the ring. Both sync and ring modulation use that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| test_i | input | 3 | Test bit per oscillator |
| sync_i | input | 3 | Hard-sync enable per oscillator |
| ring_i | input | 3 | Ring-modulation enable per oscillator |
| freq_i | input | 48 | Frequency words, oscillator k in bits 16k+15..16k |
| pw_i | input | 36 | Pulse widths, oscillator k in bits 12k+11..12k |
| saw_o | output | 36 | Sawtooth per oscillator, 12 bits each |
| tri_o | output | 36 | Triangle per oscillator, 12 bits each |
| pulse_o | output | 36 | Pulse per oscillator, 12 bits each |
| msb_rise_o | output | 3 | MSB-rising flag per oscillator |
| msb_o | output | 3 | Accumulator MSB per oscillator |

## Verification
A hard-sync clear of an oscillator and the MSB rise of that same oscillator can land on one clock. When this happens, the oscillator downstream of it must not be cleared. The bench provokes the case by giving oscillators 0 and 1 equal frequencies from reset, so both MSBs rise on the same clock while oscillators 1 and 2 have sync enabled. A cycle-accurate arithmetic model in the bench counts how often this exception fires and how often an ordinary clear fires. Every shape and flag of all three oscillators is compared against the model on every cycle, so a clear applied or withheld wrongly shows up as a sawtooth mismatch.

// File: rtl/osc_pkg.sv
package osc_pkg;
   // Index of the oscillator d steps back around a ring of n.
   function automatic int ring_back(input int k, input int n, input int d);
      return (k + n - d) % n;
   endfunction
endpackage

// File: rtl/osc_phase.sv
module osc_phase #(
   parameter int ACC_W  = 24,
   parameter int FREQ_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             test_i,
   input  logic             sync_en_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic             src_rise_c_i,
   input  logic             src_sync_en_i,
   input  logic             src2_rise_c_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             rise_c_o,
   output logic             rise_o
);
   localparam int MSB = ACC_W - 1;
   localparam int PAD = ACC_W - FREQ_W;

   if (FREQ_W > ACC_W) begin : g_bad_w
      $error("osc_phase: FREQ_W must not exceed ACC_W");
   end

   logic [ACC_W-1:0] acc_q, sum;
   logic             rise_q, hit;

   assign sum      = acc_q + {{PAD{1'b0}}, freq_i};
   assign rise_c_o = !test_i && !acc_q[MSB] && sum[MSB];
   // Clear from the source, unless the source is itself being restarted.
   assign hit      = sync_en_i && src_rise_c_i && !(src_sync_en_i && src2_rise_c_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q  <= '0;
         rise_q <= 1'b0;
      end else begin
         rise_q <= rise_c_o;
         if (test_i || hit) acc_q <= '0;
         else               acc_q <= sum;
      end
   end

   assign acc_o  = acc_q;
   assign rise_o = rise_q;

   a_r1_step: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(!rst_i) && !$past(test_i) && !$past(hit) |-> acc_q == $past(sum));
   a_r2_test_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      test_i |=> acc_q == '0);
   a_r3_rise_from_low: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_q |-> $past(!acc_q[MSB]) && !$past(test_i));
   a_r4_sync_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      hit |=> acc_q == '0);
endmodule

// File: rtl/osc_shape.sv
module osc_shape #(
   parameter int ACC_W     = 24,
   parameter int OUT_W     = 12,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             test_i,
   input  logic             ring_en_i,
   input  logic [ACC_W-1:0] acc_i,
   input  logic             src_msb_i,
   input  logic [OUT_W-1:0] pw_i,
   output logic [OUT_W-1:0] saw_o,
   output logic [OUT_W-1:0] tri_o,
   output logic [OUT_W-1:0] pulse_o
);
   localparam int MSB = ACC_W - 1;
   localparam int LO  = ACC_W - OUT_W;

   if (OUT_W > ACC_W || OUT_W < 2) begin : g_bad_w
      $error("osc_shape: OUT_W must be in 2..ACC_W");
   end

   logic [OUT_W-1:0] top;
   logic [OUT_W-2:0] body;
   logic             fold, cmp, pulse_bit;

   assign top   = acc_i[MSB:LO];
   assign saw_o = top;
   assign fold  = ring_en_i ? (acc_i[MSB] ^ ~src_msb_i) : acc_i[MSB];
   assign body  = top[OUT_W-2:0] ^ {(OUT_W-1){fold}};
   assign tri_o = {body, 1'b0};
   assign cmp   = (top >= pw_i);

   if (PULSE_REG) begin : g_pulse_reg
      logic pq;
      always_ff @(posedge clk_i) begin
         if (rst_i) pq <= 1'b0;
         else       pq <= cmp;
      end
      assign pulse_bit = pq;

      a_r9_pulse_late: assert property (@(posedge clk_i) disable iff (rst_i)
         !test_i && $past(!rst_i) |-> pulse_o == {OUT_W{$past(cmp)}});
   end else begin : g_pulse_comb
      assign pulse_bit = cmp;
   end

   assign pulse_o = test_i ? {OUT_W{1'b1}} : {OUT_W{pulse_bit}};

   a_r10_test_high: assert property (@(posedge clk_i) disable iff (rst_i)
      test_i |-> pulse_o == {OUT_W{1'b1}});
endmodule

// File: rtl/phase_osc_ring.sv
module phase_osc_ring #(
   parameter int N_OSC     = 3,
   parameter int ACC_W     = 24,
   parameter int FREQ_W    = 16,
   parameter int OUT_W     = 12,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic [N_OSC-1:0]          test_i,
   input  logic [N_OSC-1:0]          sync_i,
   input  logic [N_OSC-1:0]          ring_i,
   input  logic [N_OSC*FREQ_W-1:0]   freq_i,
   input  logic [N_OSC*OUT_W-1:0]    pw_i,
   output logic [N_OSC*OUT_W-1:0]    saw_o,
   output logic [N_OSC*OUT_W-1:0]    tri_o,
   output logic [N_OSC*OUT_W-1:0]    pulse_o,
   output logic [N_OSC-1:0]          msb_rise_o,
   output logic [N_OSC-1:0]          msb_o
);
   localparam int MSB = ACC_W - 1;

   if (N_OSC < 2) begin : g_bad_n
      $error("phase_osc_ring: need at least two oscillators");
   end

   logic [ACC_W-1:0] acc   [N_OSC];
   logic [N_OSC-1:0] rise_c;

   for (genvar k = 0; k < N_OSC; k++) begin : g_osc
      localparam int SRC  = osc_pkg::ring_back(k, N_OSC, 1);
      localparam int SRC2 = osc_pkg::ring_back(k, N_OSC, 2);

      osc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_phase (
         .clk_i        (clk_i),
         .rst_i        (rst_i),
         .test_i       (test_i[k]),
         .sync_en_i    (sync_i[k]),
         .freq_i       (freq_i[k*FREQ_W +: FREQ_W]),
         .src_rise_c_i (rise_c[SRC]),
         .src_sync_en_i(sync_i[SRC]),
         .src2_rise_c_i(rise_c[SRC2]),
         .acc_o        (acc[k]),
         .rise_c_o     (rise_c[k]),
         .rise_o       (msb_rise_o[k])
      );

      osc_shape #(.ACC_W(ACC_W), .OUT_W(OUT_W), .PULSE_REG(PULSE_REG)) u_shape (
         .clk_i    (clk_i),
         .rst_i    (rst_i),
         .test_i   (test_i[k]),
         .ring_en_i(ring_i[k]),
         .acc_i    (acc[k]),
         .src_msb_i(acc[SRC][MSB]),
         .pw_i     (pw_i[k*OUT_W +: OUT_W]),
         .saw_o    (saw_o[k*OUT_W +: OUT_W]),
         .tri_o    (tri_o[k*OUT_W +: OUT_W]),
         .pulse_o  (pulse_o[k*OUT_W +: OUT_W])
      );

      assign msb_o[k] = acc[k][MSB];

      // R12: a sync-enabled oscillator restarts when its predecessor rises alone.
      a_r12_ring_source: assert property (@(posedge clk_i) disable iff (rst_i)
         sync_i[k] && rise_c[SRC] && !sync_i[SRC] |=> acc[k] == '0);
   end
endmodule

// File: tb/phase_osc_ring_bench.sv
module phase_osc_ring_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  test, sync, ring;
   logic [47:0] freq;
   logic [35:0] pw;
   logic [35:0] saw, tri_w, pulse;
   logic [2:0]  rise, msb;

   int tests = 0, fails = 0;
   int n_clear = 0, n_except = 0;
   bit done = 1'b0;

   logic [23:0] m_acc [3];
   logic        m_pq  [3];
   logic        m_rise[3];

   always #2 clk = ~clk;

   phase_osc_ring u_phase_osc_ring (
      .clk_i(clk), .rst_i(rst), .test_i(test), .sync_i(sync), .ring_i(ring),
      .freq_i(freq), .pw_i(pw), .saw_o(saw), .tri_o(tri_w), .pulse_o(pulse),
      .msb_rise_o(rise), .msb_o(msb));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: advance the model from the requirements, then compare.
   task automatic step();
      logic [23:0] nxt [3];
      logic        rc  [3];
      for (int k = 0; k < 3; k++) begin
         nxt[k] = test[k] ? 24'd0 : m_acc[k] + {8'd0, freq[k*16 +: 16]};
         rc[k]  = !test[k] && !m_acc[k][23] && nxt[k][23];
      end
      for (int k = 0; k < 3; k++) begin
         int s1 = (k + 2) % 3;   // R12 source
         int s2 = (k + 1) % 3;
         if (sync[k] && rc[s1]) begin
            if (sync[s1] && rc[s2]) n_except++;   // R5
            else begin nxt[k] = 24'd0; n_clear++; end  // R4
         end
      end
      for (int k = 0; k < 3; k++) begin
         if (rst) begin
            m_pq[k] = 1'b0; m_rise[k] = 1'b0; m_acc[k] = 24'd0;
         end else begin
            m_pq[k]   = (m_acc[k][23:12] >= pw[k*12 +: 12]);
            m_rise[k] = rc[k];
            m_acc[k]  = nxt[k];
         end
      end
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         logic        f;
         logic [10:0] b;
         f = ring[k] ? (m_acc[k][23] ^ ~m_acc[(k + 2) % 3][23]) : m_acc[k][23];
         b = m_acc[k][22:12] ^ {11{f}};
         chk($sformatf("R1 R2 R4 R5 R6 saw osc%0d", k), {20'd0, saw[k*12 +: 12]}, {20'd0, m_acc[k][23:12]});
         chk($sformatf("R1 msb osc%0d", k), {31'd0, msb[k]}, {31'd0, m_acc[k][23]});
         chk($sformatf("R7 R8 tri osc%0d", k), {20'd0, tri_w[k*12 +: 12]}, {20'd0, b, 1'b0});
         chk($sformatf("R9 R10 pulse osc%0d", k), {20'd0, pulse[k*12 +: 12]},
             {20'd0, (test[k] ? 12'hFFF : {12{m_pq[k]}})});
         chk($sformatf("R3 rise osc%0d", k), {31'd0, rise[k]}, {31'd0, m_rise[k]});
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_reset();
      rst = 1'b1; run(3); rst = 1'b0;
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin m_acc[k] = '0; m_pq[k] = 0; m_rise[k] = 0; end
      rst = 1'b1; test = 0; sync = 0; ring = 0; freq = 0; pw = 0;
      @(negedge clk);
      do_reset();
      // R11: reset state
      chk("R11 saw after reset", {12'd0, saw[23:12], saw[11:0]}, 32'd0);
      chk("R11 pulse after reset", {28'd0, pulse[35:32]}, 32'd0);
      chk("R11 rise after reset", {29'd0, rise}, 32'd0);

      // Free run, wrap and pulse extremes (R1, R6, R9)
      freq = {16'h0800, 16'hFFFF, 16'h1234};
      pw   = {12'hFFF, 12'h000, 12'h800};
      run(1200);

      // Test hold and restart (R2, R10)
      test = 3'b010; run(20);
      test = 3'b000; run(300);
      test = 3'b111; pw = {12'h001, 12'h7FF, 12'hFFF}; run(10);
      test = 3'b000; run(300);

      // Ring modulation (R7, R8)
      ring = 3'b111; freq = {16'h0700, 16'h0C00, 16'h1500}; run(800);
      ring = 3'b010; run(300);
      ring = 3'b000;

      // Ordinary hard sync (R4, R12)
      do_reset();
      sync = 3'b010; freq = {16'h0400, 16'h2100, 16'h9000}; run(1500);
      chk("R4 R12 ordinary sync clear reached", {31'd0, n_clear > 0}, 32'd1);

      // Same-cycle exception (R5): osc0 and osc1 rise together
      do_reset();
      sync = 3'b110; freq = {16'h3000, 16'h8000, 16'h8000}; run(1600);
      chk("R5 exception reached", {31'd0, n_except > 0}, 32'd1);
      sync = 3'b000;

      // Mixed pseudo-random phases
      for (int p = 0; p < 40; p++) begin
         freq = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         pw   = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
         sync = 3'($urandom); ring = 3'($urandom);
         test = (p % 7 == 3) ? 3'($urandom) : 3'b000;
         run(60);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule